// File: doc/BRIEF.md
# Four-Channel DAC Code Loader

This block is the bus-side front end for four 12-bit converter channels. Software loads a value in two byte writes. The first write carries the low eight data bits. The second write carries the upper four data bits and the number of the target channel. The second write stages the complete code and starts a fixed loading interval, and a busy flag stays up for the whole interval. The staged code reaches the selected channel's output register only when software later reads the upper-byte location after busy has dropped. A write therefore prepares an update, and a read strobe applies it.

The same read-only status location also reports the busy flag, an externally supplied calibration-busy flag and four general-purpose input pins. The four channel output registers leave the block as one packed bus. The analog converter itself is outside this block.

Top module: `dac_load_if`

## Requirements
- R1: While reset is asserted, all four output codes are zero and busy is low.
- R2: A write to the low-byte location (offset 4) on its own changes no output code and does not raise busy.
- R3: A write to the high-byte location (offset 5) raises busy for exactly LOAD_CYCLES clock cycles (default 8), counted from the clock edge that takes the write.
- R4: In the high byte, bits 7:6 select the channel (0 to 3) and bits 3:0 become code bits 11:8. The most recent low byte becomes code bits 7:0. Bits 5:4 are ignored.
- R5: A read of offset 5 taken while busy is low, with a staged code pending, copies that code into the selected channel's output register at that clock edge. The other three channels are left unchanged.
- R6: A read of offset 5 while busy is high has no effect on the outputs. The staged code stays pending and is applied by a later read once busy is low.
- R7: A high-byte write that arrives while busy is high replaces the staged code and channel and restarts the full busy interval.
- R8: Reading offset 4 returns busy in bit 7, the calibration-busy input in bit 6, the four input pins in bits 3:0, and zeros in bits 5:4.
- R9: Reading offset 5 returns the staged channel in bits 7:6, zeros in bits 5:4 and staged code bits 11:8 in bits 3:0. Reading any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset (combinational) |
| cal_busy | input | 1 | Calibration-busy flag, reported in status |
| aux_in | input | 4 | General-purpose input pins, reported in status |
| busy | output | 1 | High while a staged load is in its loading interval |
| dac_codes | output | 48 | Output codes; channel i in bits [12*i+11 : 12*i] |

## Verification
If the channel field is decoded wrongly, the new code appears on a different channel's slice of the output bus. This shows up on the read edge that applies the update. If the busy counter is wrong, the fall of busy moves off cycle LOAD_CYCLES after the write, and a read placed at the expected cycle is then either ignored or applied too soon. A staged code that is lost or wrongly kept shows up on the first apply read that follows, or on a read taken during the busy interval.

// File: rtl/dac_load_pkg.sv
`timescale 1ns/1ps
package dac_load_pkg;
  localparam int BYTE_W    = 8;
  localparam int CODE_W    = 12;
  localparam int NUM_CH    = 4;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int HI_DATA_W = CODE_W - BYTE_W;
  localparam int CH_LSB    = BYTE_W - CH_W;
  localparam int AUX_W     = 4;
  localparam int BUS_W     = NUM_CH * CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CH_W-1:0]   chan_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  valid;
    chan_t ch;
    code_t code;
  } stage_t;

  function automatic code_t join_code(input byte_t lo, input byte_t hi);
    return {hi[HI_DATA_W-1:0], lo};
  endfunction

  function automatic chan_t chan_field(input byte_t hi);
    return hi[CH_LSB +: CH_W];
  endfunction

  function automatic byte_t status_byte(input logic bsy, input logic cal,
                                        input logic [AUX_W-1:0] aux);
    return {bsy, cal, 2'b00, aux};
  endfunction

  function automatic byte_t hi_view(input chan_t ch, input code_t c);
    byte_t v;
    v = '0;
    v[CH_LSB +: CH_W] = ch;
    v[HI_DATA_W-1:0]  = c[CODE_W-1 -: HI_DATA_W];
    return v;
  endfunction
endpackage

// File: rtl/dac_stage.sv
`timescale 1ns/1ps
module dac_stage
  import dac_load_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lo_wr,
  input  logic   hi_wr,
  input  logic   commit,
  input  byte_t  wdata,
  output stage_t stg
);
  byte_t lo_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_hold <= '0;
    end else if (lo_wr) begin
      lo_hold <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else if (hi_wr) begin
      stg.valid <= 1'b1;
      stg.ch    <= chan_field(wdata);
      stg.code  <= join_code(lo_hold, wdata);
    end else if (commit) begin
      stg.valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_busy_timer.sv
`timescale 1ns/1ps
module dac_busy_timer #(
  parameter int LOAD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(LOAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOAD_CYCLES);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= CNT_LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/dac_out_bank.sv
`timescale 1ns/1ps
module dac_out_bank
  import dac_load_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  stage_t           stg,
  output logic [BUS_W-1:0] codes
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    code_t held;
    logic  hit;
    assign hit = commit && (stg.ch == chan_t'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held <= '0;
      end else if (hit) begin
        held <= stg.code;
      end
    end
    assign codes[i*CODE_W +: CODE_W] = held;
  end
endmodule

// File: rtl/dac_load_if.sv
`timescale 1ns/1ps
module dac_load_if
  import dac_load_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int LO_OFFSET   = 4,
  parameter int HI_OFFSET   = 5,
  parameter int LOAD_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  input  logic                  cal_busy,
  input  logic [3:0]            aux_in,
  output logic                  busy,
  output logic [4*12-1:0]       dac_codes
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(LO_OFFSET);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(HI_OFFSET);

  logic   sel_lo, sel_hi;
  logic   lo_wr_evt, hi_wr_evt, rd_lo, rd_hi, commit_evt;
  stage_t stg;

  assign sel_lo     = (addr == A_LO);
  assign sel_hi     = (addr == A_HI);
  assign lo_wr_evt  = wr_en && sel_lo;
  assign hi_wr_evt  = wr_en && sel_hi;
  assign rd_lo      = rd_en && sel_lo;
  assign rd_hi      = rd_en && sel_hi;
  assign commit_evt = rd_hi && !busy && stg.valid && !hi_wr_evt;

  dac_stage u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_wr  (lo_wr_evt),
    .hi_wr  (hi_wr_evt),
    .commit (commit_evt),
    .wdata  (wdata),
    .stg    (stg)
  );

  dac_busy_timer #(.LOAD_CYCLES(LOAD_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (hi_wr_evt),
    .busy  (busy)
  );

  dac_out_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit_evt),
    .stg    (stg),
    .codes  (dac_codes)
  );

  always_comb begin
    if (sel_lo)      rdata = status_byte(busy, cal_busy, aux_in);
    else if (sel_hi) rdata = hi_view(stg.ch, stg.code);
    else             rdata = '0;
  end
endmodule

// File: rtl/dac_load_chk.sv
`timescale 1ns/1ps
module dac_load_chk
  import dac_load_pkg::*;
#(
  parameter int LOAD_CYCLES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hi_wr_evt,
  input logic             commit_evt,
  input logic             busy,
  input logic             rd_lo,
  input logic [7:0]       rdata,
  input logic [BUS_W-1:0] dac_codes
);
  localparam int RUN_W = $clog2(LOAD_CYCLES + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOAD_CYCLES);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run <= '0;
    else if (hi_wr_evt) run <= '0;
    else if (busy)      run <= run + 1'b1;
    else                run <= '0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (dac_codes == '0 && !busy)); // R1

  AST_HOLD_WITHOUT_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(dac_codes)); // R2

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_evt |=> busy); // R3

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_MAX); // R3

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run == RUN_MAX) |-> !busy); // R3

  AST_NO_APPLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> !busy); // R6

  AST_STATUS_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |-> (rdata[7] == busy)); // R8
endmodule

bind dac_load_if dac_load_chk #(.LOAD_CYCLES(LOAD_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hi_wr_evt  (hi_wr_evt),
  .commit_evt (commit_evt),
  .busy       (busy),
  .rd_lo      (rd_lo),
  .rdata      (rdata),
  .dac_codes  (dac_codes)
);

// File: tb/tb_dac_load_if.sv
`timescale 1ns/1ps
module tb_dac_load_if;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        cal_busy = 1'b0;
  logic [3:0]  aux_in = '0;
  logic        busy;
  logic [47:0] dac_codes;

  int vectors = 0;
  int miscompares = 0;
  logic [11:0] model [4];

  always #2 clk = ~clk;

  dac_load_if #(.LOAD_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cal_busy(cal_busy), .aux_in(aux_in),
    .busy(busy), .dac_codes(dac_codes)
  );

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] model_bus();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 4 * N) begin
      n++;
      @(posedge clk); @(negedge clk);
    end
  endtask

  function automatic logic [7:0] hi_byte(input int ch, input logic [11:0] c, input logic [1:0] junk);
    return {2'(ch), junk, c[11:8]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 codes in reset", dac_codes, '0);
    check("R1 busy in reset", {47'd0, busy}, 48'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: status byte sweep over pins and calibration flag
    for (int cb = 0; cb < 2; cb++) begin
      for (int p = 0; p < 16; p++) begin
        cal_busy = cb[0]; aux_in = 4'(p);
        bus_read(4'd4, rd);
        check("R8 status idle", {40'd0, rd}, {40'd0, 1'b0, cb[0], 2'b00, 4'(p)});
      end
    end

    // R2: a low byte alone changes nothing
    bus_write(4'd4, 8'hA5);
    check("R2 busy after low write", {47'd0, busy}, 48'd0);
    check("R2 codes after low write", dac_codes, model_bus());
    bus_read(4'd5, rd);
    check("R2 codes after apply read", dac_codes, model_bus());

    // R3 R4 R5 R9: sweep every channel with several codes
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 6; k++) begin
        logic [11:0] c;
        c = 12'((ch * 12'h3A7 + k * 12'h19D + 12'h011) & 12'hFFF);
        bus_write(4'd4, c[7:0]);
        bus_write(4'd5, hi_byte(ch, c, 2'(k)));
        bus_read(4'd4, rd);
        check("R8 busy bit during load", {47'd0, rd[7]}, 48'd1);
        bus_read(4'd5, rd);
        check("R9 high readback", {40'd0, rd}, {40'd0, 2'(ch), 2'b00, c[11:8]});
        check("R6 no apply while busy", dac_codes, model_bus());
        busy_len(n);
        check("R3 busy length", 48'(n), 48'(N - 2));
        bus_read(4'd5, rd);
        model[ch] = c;
        check("R5 R4 apply to channel", dac_codes, model_bus());
      end
    end

    // R3: exact busy interval measured from the write edge
    bus_write(4'd4, 8'h3C);
    bus_write(4'd5, hi_byte(2, 12'h93C, 2'b00));
    busy_len(n);
    check("R3 exact busy interval", 48'(n), 48'(N));
    bus_read(4'd5, rd);
    model[2] = 12'h93C;
    check("R5 apply after interval", dac_codes, model_bus());

    // R6: read during busy is ignored, later read applies
    bus_write(4'd4, 8'h7E);
    bus_write(4'd5, hi_byte(1, 12'h57E, 2'b00));
    bus_read(4'd5, rd);
    check("R6 early read ignored", dac_codes, model_bus());
    busy_len(n);
    check("R6 still idle before apply", dac_codes, model_bus());
    bus_read(4'd5, rd);
    model[1] = 12'h57E;
    check("R6 pending code applied later", dac_codes, model_bus());

    // R7: second high write during busy replaces and restarts
    bus_write(4'd4, 8'h11);
    bus_write(4'd5, hi_byte(0, 12'hF11, 2'b00));
    repeat (3) @(negedge clk);
    bus_write(4'd5, hi_byte(3, 12'h211, 2'b00));
    busy_len(n);
    check("R7 busy restarted", 48'(n), 48'(N));
    bus_read(4'd5, rd);
    model[3] = 12'h211;
    check("R7 replaced code applied", dac_codes, model_bus());

    // R9: other offsets read zero
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 5) begin
        bus_read(4'(a), rd);
        check("R9 unused offset", {40'd0, rd}, 48'd0);
      end
    end

    // R1: reset again clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) model[i] = '0;
    check("R1 codes after reset", dac_codes, model_bus());
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule